// File: doc/BRIEF.md
# Function-Coded ALU with Status Outputs

This block is an arithmetic logic unit of parameterised width (16 bits by default). It takes two operands and a 3-bit function code. It returns a result word and three status bits: a carry/borrow bit, a zero indication and an unsigned A-above-B comparison.

Six function codes are defined: add, subtract, decrement of A, bitwise AND, bitwise OR and complement of A. The two remaining codes are reserved and produce a cleared result with carry clear. The datapath is combinational. A parameter selects whether an output register stage follows it. With the register, the outputs update one clock after the operands and code are presented. The default build includes the register.

Top module: `alu_unit`

## Requirements
- R1: Code 3'b000 gives Y = A + B modulo 2^W, with carry equal to the carry out of bit W-1.
- R2: Code 3'b001 gives Y = A - B modulo 2^W, with carry set exactly when B > A unsigned (borrow out).
- R3: Code 3'b010 gives Y = A - 1 modulo 2^W, with carry set exactly when A = 0 (borrow out).
- R4: Code 3'b011 gives Y = A AND B, and code 3'b100 gives Y = A OR B; carry is 0 for both.
- R5: Code 3'b101 gives Y = NOT A (bitwise), with carry 0.
- R6: Codes 3'b110 and 3'b111 give Y = 0 with carry 0.
- R7: The zero output is 1 exactly when the final Y is all zeros, whatever the function code.
- R8: The compare output is 1 exactly when A > B as unsigned numbers, whatever the function code.
- R9: With the output register enabled (default), all outputs reflect the inputs sampled at the previous rising clock edge. While rst_ni is low, Y = 0, carry = 0, compare = 0 and zero = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| func_i | input | 3 | Function code |
| y_o | output | W | Result |
| carry_o | output | 1 | Carry out (add) or borrow out (subtract, decrement) |
| zero_o | output | 1 | Result is zero |
| gt_o | output | 1 | A > B, unsigned |

## Verification
Every result, including the zero and compare bits, is due one rising edge after its operands and code are driven. The bench drives inputs on a falling edge. It compares all four outputs against its reference on the next falling edge, after the single register has captured them. Just after each new input set is driven, and before the capturing edge, the bench confirms that the outputs still hold the previous result. This shows that nothing leaks through combinationally in the registered build.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_DEC  = 3'b010,
    OP_AND  = 3'b011,
    OP_OR   = 3'b100,
    OP_NOTA = 3'b101,
    OP_RSV6 = 3'b110,
    OP_RSV7 = 3'b111
  } alu_op_e;

  function automatic logic is_logic_op(alu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_NOTA);
  endfunction
endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  localparam int XW = W + 1;

  logic [XW-1:0] a_x, b_x, one_x, ext;

  assign a_x   = {1'b0, a_i};
  assign b_x   = {1'b0, b_i};
  assign one_x = XW'(1);

  // top bit of the widened result is carry (add) or borrow (sub/dec)
  always_comb begin
    case (op_i)
      OP_ADD:  ext = a_x + b_x;
      OP_SUB:  ext = a_x - b_x;
      OP_DEC:  ext = a_x - one_x;
      default: ext = '0;
    endcase
  end

  assign res_o  = ext[W-1:0];
  assign cout_o = ext[W];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_NOTA: res_o = ~a_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] y_i,
  output logic         zero_o,
  output logic         gt_o
);
  assign zero_o = ~|y_i;
  assign gt_o   = a_i > b_i;
endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_pkg::*;
#(
  parameter int W       = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   func_i,
  output logic [W-1:0] y_o,
  output logic         carry_o,
  output logic         zero_o,
  output logic         gt_o
);
  alu_op_e      op;
  logic [W-1:0] arith_res, logic_res, y_c;
  logic         arith_cout, carry_c, zero_c, gt_c;

  assign op = alu_op_e'(func_i);

  alu_arith #(.W(W)) u_arith (
    .a_i(a_i), .b_i(b_i), .op_i(op), .res_o(arith_res), .cout_o(arith_cout)
  );

  alu_logic #(.W(W)) u_logic (
    .a_i(a_i), .b_i(b_i), .op_i(op), .res_o(logic_res)
  );

  // each unit returns zero for codes it does not own
  always_comb begin
    if (is_logic_op(op)) begin
      y_c     = logic_res;
      carry_c = 1'b0;
    end else begin
      y_c     = arith_res;
      carry_c = arith_cout;
    end
  end

  alu_flags #(.W(W)) u_flags (
    .a_i(a_i), .b_i(b_i), .y_i(y_c), .zero_o(zero_c), .gt_o(gt_c)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        y_o     <= '0;
        carry_o <= 1'b0;
        zero_o  <= 1'b1;
        gt_o    <= 1'b0;
      end else begin
        y_o     <= y_c;
        carry_o <= carry_c;
        zero_o  <= zero_c;
        gt_o    <= gt_c;
      end
    end

    AST_RSV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (func_i[2:1] == 2'b11) |=> (y_o == '0 && !carry_o)); // R6
    AST_LOGIC_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (func_i == 3'b011 || func_i == 3'b100 || func_i == 3'b101) |=> !carry_o); // R4
    AST_DEC_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (func_i == 3'b010) |=> (y_o == $past(a_i) - W'(1))); // R3
    AST_ZERO_TRACKS_Y: assert property (@(posedge clk_i) disable iff (!rst_ni)
      zero_o == (y_o == '0)); // R7
    AST_GT_UNSIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (gt_o == ($past(a_i) > $past(b_i)))); // R8
  end else begin : g_comb
    assign y_o     = y_c;
    assign carry_o = carry_c;
    assign zero_o  = zero_c;
    assign gt_o    = gt_c;
  end
endmodule

// File: tb/sim_alu_unit.sv
module sim_alu_unit;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [2:0]   f = 3'b000;
  logic [W-1:0] y;
  logic         cy, zf, gt;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [W-1:0] exp_y;
  logic         exp_c, exp_z, exp_g;

  always #5 clk = ~clk;

  alu_unit #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a), .b_i(b), .func_i(f),
    .y_o(y), .carry_o(cy), .zero_o(zf), .gt_o(gt)
  );

  task automatic chk(string tag, longint got, longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h (a=%0h b=%0h f=%0b)", tag, got, exp, a, b, f);
    end
  endtask

  // behavioural reference
  task automatic model(input int av, input int bv, input int fv);
    int r;
    r = 0;
    exp_c = 1'b0;
    case (fv)
      0: begin r = av + bv; exp_c = (r >= 65536); end
      1: begin r = av - bv; exp_c = (bv > av); end
      2: begin r = av - 1;  exp_c = (av == 0); end
      3: r = av & bv;
      4: r = av | bv;
      5: r = ~av;
      default: r = 0;
    endcase
    exp_y = W'(r & 32'hFFFF);
    exp_z = (exp_y == '0);
    exp_g = (av > bv);
  endtask

  function automatic string op_tag(int fv);
    case (fv)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3, 4: return "R4";
      5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic [2:0] fv);
    logic [W-1:0] prev_y;
    prev_y = exp_y;
    a = av; b = bv; f = fv;
    #1;
    chk("R9 hold before edge", y, prev_y);
    model(int'(av), int'(bv), int'(fv));
    @(negedge clk);
    chk({op_tag(int'(fv)), " result"}, y, exp_y);
    chk({op_tag(int'(fv)), " carry"}, cy, exp_c);
    chk("R7 zero", zf, exp_z);
    chk("R8 compare", gt, exp_g);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    a = 16'h1234; b = 16'h0001; f = 3'b000;
    repeat (3) @(negedge clk);
    chk("R9 reset y", y, 0);
    chk("R9 reset carry", cy, 0);
    chk("R9 reset zero", zf, 1);
    chk("R9 reset gt", gt, 0);
    exp_y = '0;
    rst_ni = 1'b1;
    a = '0; b = '0;
    @(negedge clk);
    exp_y = '0;

    apply(16'hFFFF, 16'h0001, 3'b000); // R1 wrap with carry, zero set
    apply(16'h1234, 16'h4321, 3'b000); // R1
    apply(16'h0005, 16'h0009, 3'b001); // R2 borrow
    apply(16'h0009, 16'h0009, 3'b001); // R2 zero, equal -> gt 0
    apply(16'h8000, 16'h7FFF, 3'b001); // R2 unsigned compare
    apply(16'h0000, 16'hFFFF, 3'b010); // R3 borrow from zero
    apply(16'h0001, 16'h0000, 3'b010); // R3 to zero
    apply(16'hF0F0, 16'h0FF0, 3'b011); // R4 and
    apply(16'hF000, 16'h0F00, 3'b011); // R4 and -> 0
    apply(16'hF000, 16'h000F, 3'b100); // R4 or
    apply(16'hFFFF, 16'h0000, 3'b101); // R5 not -> 0
    apply(16'h00FF, 16'h1234, 3'b101); // R5
    apply(16'hFFFF, 16'hFFFF, 3'b110); // R6
    apply(16'h0001, 16'h0000, 3'b111); // R6

    for (int i = 0; i < 400; i++) begin
      apply(W'($urandom), W'($urandom), 3'($urandom));
    end
    for (int i = 0; i < 8; i++) begin
      apply(16'h8000, 16'h8000, 3'(i)); // R8 equal operands, every code
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule